// File: doc/BRIEF.md
# Counter Memory Write-Back Scanner

This block keeps an external copy of an on-chip counter memory up to date. It walks two windows of that memory without stopping. The first window holds the 64 global-register words and is copied to a global base address. The second window holds 512 fast-counter words, starting at word 128, and is copied to a separate statistics base address. Each copy step moves one burst of eight consecutive words. The external address steps by 32 bytes per burst and returns to its base when a window starts again. When the second window is finished, the walk starts over at the first window.

The scanner shares the counter memory with the engine that performs counting operations. It takes the memory only after that engine has reported a fixed number of completed operations, seven by default. It then raises a hold signal, which stops the engine, and reads the eight words of one burst in back-to-back cycles. This gives a consistent snapshot of the burst. It then lets the engine run again and sends the snapshot over a simple burst-write handshake. The memory read port is expected to return data one cycle after the request.

Top module: `ctr_mirror_scan`

## Requirements
- R1: The read phase of a burst begins only after at least OPS_PER_BURST (default 7) op_done pulses have been registered since the previous grant. An op_done pulse in the grant cycle counts toward the next burst. With the scanner idle, mem_hold rises on the clock edge after the edge that registers the seventh pulse.
- R2: mem_hold and mem_rd_en stay high for exactly BURST_LEN (8) consecutive cycles per burst. mem_rd_addr rises by one each cycle, starting at the first word of the burst.
- R3: Each burst carries exactly BURST_LEN beats on the write port. The beats hold the words read during the hold window, in ascending address order. wb_last is high only on the final beat.
- R4: Bursts of the first window (words 0 to 63) go to GLB_BASE + 32*k. Bursts of the second window (words 128 to 639) go to STAT_BASE + 32*k. Here k is the burst number within its own window, counted from 0.
- R5: Bursts run in this order: the 8 bursts of the first window, then the 64 bursts of the second window, then the first window again. A full pass is 72 bursts.
- R6: While wb_valid is high and wb_ready is low, wb_valid, wb_addr, wb_data and wb_last hold their values.
- R7: pass_done is a one-cycle pulse. It is high in the cycle after the final beat of the last burst of the second window is accepted, and low at all other times.
- R8: During and right after reset, mem_hold, mem_rd_en, wb_valid and pass_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_done | input | 1 | Pulse from the update engine for each completed counting operation |
| mem_hold | output | 1 | Stops the update engine while a burst is read |
| mem_rd_en | output | 1 | Counter memory read request |
| mem_rd_addr | output | MEM_AW | Counter memory word address |
| mem_rd_data | input | WORD_W | Read data, valid one cycle after the request |
| wb_valid | output | 1 | Write-back beat valid |
| wb_ready | input | 1 | External side accepts the current beat |
| wb_addr | output | EXT_AW | External byte address of the current burst |
| wb_data | output | WORD_W | Beat data |
| wb_last | output | 1 | Final beat of the burst |
| pass_done | output | 1 | Pulse when a full pass over both windows completes |

## Verification
The checker tests these rules on every cycle:
- the write port is held steady under backpressure;
- reads are consecutive and stay inside the two windows;
- each hold window is exactly eight cycles long;
- each burst has exactly eight beats, with the last flag on the final one;
- the minimum count of operations between grants is met;
- pass_done appears only right after a final beat.

Only the bench scenarios can show the rest. That covers:
- the exact data carried, against a memory that the engine model keeps changing between bursts;
- the address and window sequence over two full passes and the wrap;
- the exact cycle at which the grant follows the seventh operation.

// File: rtl/ctr_mirror_pkg.sv
package ctr_mirror_pkg;

   typedef enum logic [1:0] {
      SC_IDLE  = 2'd0,
      SC_READ  = 2'd1,
      SC_DRAIN = 2'd2
   } scan_state_e;

   // index width that is never zero
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mirror_credit.sv
module mirror_credit #(
   parameter int unsigned OPS_PER_BURST = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic op_done,
   input  logic take,
   output logic eligible
);

   generate
      if (OPS_PER_BURST == 0) begin : g_free
         logic unused_in;
         assign unused_in = op_done ^ take ^ clk ^ rst_n;
         assign eligible  = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(OPS_PER_BURST + 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (take) begin
               cnt_q <= CW'(op_done);
            end else if (op_done && (cnt_q != CW'(OPS_PER_BURST))) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign eligible = (cnt_q == CW'(OPS_PER_BURST));
      end
   endgenerate

endmodule

// File: rtl/mirror_walker.sv
module mirror_walker
   import ctr_mirror_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned MEM_AW    = 10,
   parameter int unsigned EXT_AW    = 32,
   parameter int unsigned BURST_LEN = 8,
   parameter int unsigned R0_START  = 0,
   parameter int unsigned R0_WORDS  = 64,
   parameter int unsigned R1_START  = 128,
   parameter int unsigned R1_WORDS  = 512,
   parameter logic [EXT_AW-1:0] GLB_BASE  = '0,
   parameter logic [EXT_AW-1:0] STAT_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   output logic [MEM_AW-1:0] word_base,
   output logic [EXT_AW-1:0] ext_addr,
   output logic              pass_done
);

   localparam int unsigned R0_BURSTS   = R0_WORDS / BURST_LEN;
   localparam int unsigned R1_BURSTS   = R1_WORDS / BURST_LEN;
   localparam int unsigned MAX_BURSTS  = (R0_BURSTS > R1_BURSTS) ? R0_BURSTS : R1_BURSTS;
   localparam int unsigned IDX_W       = idx_bits(MAX_BURSTS);
   localparam int unsigned BURST_BYTES = BURST_LEN * (WORD_W / 8);

   logic             second_q;
   logic [IDX_W-1:0] idx_q;
   logic             at_end;

   assign at_end = second_q ? (idx_q == IDX_W'(R1_BURSTS - 1))
                            : (idx_q == IDX_W'(R0_BURSTS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         second_q  <= 1'b0;
         idx_q     <= '0;
         pass_done <= 1'b0;
      end else begin
         pass_done <= advance && second_q && at_end;
         if (advance) begin
            if (at_end) begin
               second_q <= ~second_q;
               idx_q    <= '0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign word_base = (second_q ? MEM_AW'(R1_START) : MEM_AW'(R0_START))
                    + MEM_AW'(idx_q) * MEM_AW'(BURST_LEN);
   assign ext_addr  = (second_q ? STAT_BASE : GLB_BASE)
                    + EXT_AW'(idx_q) * EXT_AW'(BURST_BYTES);

endmodule

// File: rtl/mirror_snap_buf.sv
module mirror_snap_buf
   import ctr_mirror_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned BURST_LEN = 8,
   localparam int unsigned BI_W     = idx_bits(BURST_LEN)
) (
   input  logic              clk,
   input  logic              cap_en,
   input  logic [BI_W-1:0]   cap_idx,
   input  logic [WORD_W-1:0] cap_data,
   input  logic [BI_W-1:0]   rd_idx,
   output logic [WORD_W-1:0] rd_data
);

   logic [WORD_W-1:0] slots [BURST_LEN];

   generate
      for (genvar i = 0; i < BURST_LEN; i++) begin : g_slot
         logic [WORD_W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (cap_en && (cap_idx == BI_W'(i))) begin
               slot_q <= cap_data;
            end
         end
         assign slots[i] = slot_q;
      end
   endgenerate

   assign rd_data = slots[rd_idx];

endmodule

// File: rtl/ctr_mirror_scan.sv
module ctr_mirror_scan
   import ctr_mirror_pkg::*;
#(
   parameter int unsigned WORD_W        = 32,
   parameter int unsigned MEM_AW        = 10,
   parameter int unsigned EXT_AW        = 32,
   parameter int unsigned BURST_LEN     = 8,
   parameter int unsigned R0_START      = 0,
   parameter int unsigned R0_WORDS      = 64,
   parameter int unsigned R1_START      = 128,
   parameter int unsigned R1_WORDS      = 512,
   parameter int unsigned OPS_PER_BURST = 7,
   parameter logic [EXT_AW-1:0] GLB_BASE  = EXT_AW'(32'h0000_0000),
   parameter logic [EXT_AW-1:0] STAT_BASE = EXT_AW'(32'h0001_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_done,
   output logic              mem_hold,
   output logic              mem_rd_en,
   output logic [MEM_AW-1:0] mem_rd_addr,
   input  logic [WORD_W-1:0] mem_rd_data,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [EXT_AW-1:0] wb_addr,
   output logic [WORD_W-1:0] wb_data,
   output logic              wb_last,
   output logic              pass_done
);

   localparam int unsigned BI_W = idx_bits(BURST_LEN);
   localparam logic [BI_W-1:0] LAST_IDX = BI_W'(BURST_LEN - 1);

   generate
      if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_len
         $error("BURST_LEN must be a power of two of at least 2");
      end
      if ((R0_WORDS % BURST_LEN) != 0 || (R1_WORDS % BURST_LEN) != 0
          || R0_WORDS == 0 || R1_WORDS == 0) begin : g_bad_win
         $error("window sizes must be nonzero multiples of BURST_LEN");
      end
      if ((R0_START + R0_WORDS) > (2 ** MEM_AW) || (R1_START + R1_WORDS) > (2 ** MEM_AW)) begin : g_bad_aw
         $error("windows do not fit the MEM_AW address space");
      end
      if ((WORD_W % 8) != 0) begin : g_bad_w
         $error("WORD_W must be a whole number of bytes");
      end
   endgenerate

   scan_state_e     state_q;
   logic [BI_W-1:0] rd_cnt_q;
   logic [BI_W-1:0] beat_q;
   logic            cap_v_q;
   logic [BI_W-1:0] cap_idx_q;
   logic            eligible;
   logic            grant;
   logic            advance;
   logic [MEM_AW-1:0] word_base;

   assign grant   = (state_q == SC_IDLE) && eligible;
   assign advance = wb_valid && wb_ready && wb_last;

   mirror_credit #(.OPS_PER_BURST(OPS_PER_BURST)) u_credit (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_done  (op_done),
      .take     (grant),
      .eligible (eligible)
   );

   mirror_walker #(
      .WORD_W    (WORD_W),
      .MEM_AW    (MEM_AW),
      .EXT_AW    (EXT_AW),
      .BURST_LEN (BURST_LEN),
      .R0_START  (R0_START),
      .R0_WORDS  (R0_WORDS),
      .R1_START  (R1_START),
      .R1_WORDS  (R1_WORDS),
      .GLB_BASE  (GLB_BASE),
      .STAT_BASE (STAT_BASE)
   ) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (advance),
      .word_base (word_base),
      .ext_addr  (wb_addr),
      .pass_done (pass_done)
   );

   mirror_snap_buf #(.WORD_W(WORD_W), .BURST_LEN(BURST_LEN)) u_buf (
      .clk      (clk),
      .cap_en   (cap_v_q),
      .cap_idx  (cap_idx_q),
      .cap_data (mem_rd_data),
      .rd_idx   (beat_q),
      .rd_data  (wb_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SC_IDLE;
         rd_cnt_q  <= '0;
         beat_q    <= '0;
         cap_v_q   <= 1'b0;
         cap_idx_q <= '0;
      end else begin
         cap_v_q   <= (state_q == SC_READ);
         cap_idx_q <= rd_cnt_q;
         unique case (state_q)
            SC_IDLE: begin
               if (grant) begin
                  state_q  <= SC_READ;
                  rd_cnt_q <= '0;
               end
            end
            SC_READ: begin
               rd_cnt_q <= rd_cnt_q + 1'b1;
               if (rd_cnt_q == LAST_IDX) begin
                  state_q <= SC_DRAIN;
                  beat_q  <= '0;
               end
            end
            SC_DRAIN: begin
               if (wb_ready) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == LAST_IDX) begin
                     state_q <= SC_IDLE;
                  end
               end
            end
            default: state_q <= SC_IDLE;
         endcase
      end
   end

   assign mem_hold    = (state_q == SC_READ);
   assign mem_rd_en   = (state_q == SC_READ);
   assign mem_rd_addr = word_base + MEM_AW'(rd_cnt_q);
   assign wb_valid    = (state_q == SC_DRAIN);
   assign wb_last     = (state_q == SC_DRAIN) && (beat_q == LAST_IDX);

endmodule

// File: rtl/ctr_mirror_scan_chk.sv
module ctr_mirror_scan_chk #(
   parameter int unsigned WORD_W        = 32,
   parameter int unsigned MEM_AW        = 10,
   parameter int unsigned EXT_AW        = 32,
   parameter int unsigned BURST_LEN     = 8,
   parameter int unsigned R0_START      = 0,
   parameter int unsigned R0_WORDS      = 64,
   parameter int unsigned R1_START      = 128,
   parameter int unsigned R1_WORDS      = 512,
   parameter int unsigned OPS_PER_BURST = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_done,
   input logic              mem_hold,
   input logic              mem_rd_en,
   input logic [MEM_AW-1:0] mem_rd_addr,
   input logic              wb_valid,
   input logic              wb_ready,
   input logic [EXT_AW-1:0] wb_addr,
   input logic [WORD_W-1:0] wb_data,
   input logic              wb_last,
   input logic              pass_done
);

   localparam int unsigned CW = $clog2(OPS_PER_BURST + 2) + 1;
   localparam int unsigned HW = $clog2(BURST_LEN + 1) + 1;

   logic          hold_q;
   logic          last_op_q;
   logic [CW-1:0] ops_seen_q;
   logic [HW-1:0] hold_run_q;
   logic [HW-1:0] beats_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q     <= 1'b0;
         last_op_q  <= 1'b0;
         ops_seen_q <= '0;
         hold_run_q <= '0;
         beats_q    <= '0;
      end else begin
         hold_q    <= mem_hold;
         last_op_q <= op_done;
         if (mem_hold && !hold_q) begin
            ops_seen_q <= CW'(last_op_q) + CW'(op_done);
         end else if (op_done && !(&ops_seen_q)) begin
            ops_seen_q <= ops_seen_q + 1'b1;
         end
         hold_run_q <= mem_hold ? hold_run_q + 1'b1 : '0;
         if (wb_valid && wb_ready) begin
            beats_q <= wb_last ? '0 : beats_q + 1'b1;
         end
      end
   end

   // R1
   credit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_hold && !hold_q) |-> ((ops_seen_q - CW'(last_op_q)) >= CW'(OPS_PER_BURST)));

   // R2
   hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_hold && hold_q) |-> (hold_run_q == HW'(BURST_LEN)));

   // R2
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + 1'b1));

   // R4
   rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> ((32'(mem_rd_addr) >= R0_START && 32'(mem_rd_addr) < R0_START + R0_WORDS)
                  || (32'(mem_rd_addr) >= R1_START && 32'(mem_rd_addr) < R1_START + R1_WORDS)));

   // R3
   beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_ready) |-> (wb_last == (beats_q == HW'(BURST_LEN - 1))));

   // R6
   stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data) && $stable(wb_last)));

   // R7
   pass_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |-> $past(wb_valid && wb_ready && wb_last));

   // R7
   pass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> !pass_done);

endmodule

bind ctr_mirror_scan ctr_mirror_scan_chk #(
   .WORD_W        (WORD_W),
   .MEM_AW        (MEM_AW),
   .EXT_AW        (EXT_AW),
   .BURST_LEN     (BURST_LEN),
   .R0_START      (R0_START),
   .R0_WORDS      (R0_WORDS),
   .R1_START      (R1_START),
   .R1_WORDS      (R1_WORDS),
   .OPS_PER_BURST (OPS_PER_BURST)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_done     (op_done),
   .mem_hold    (mem_hold),
   .mem_rd_en   (mem_rd_en),
   .mem_rd_addr (mem_rd_addr),
   .wb_valid    (wb_valid),
   .wb_ready    (wb_ready),
   .wb_addr     (wb_addr),
   .wb_data     (wb_data),
   .wb_last     (wb_last),
   .pass_done   (pass_done)
);

// File: tb/ctr_mirror_scan_tb.sv
module ctr_mirror_scan_tb;

   localparam logic [31:0] GLB  = 32'h1000_0000;
   localparam logic [31:0] STAT = 32'h2000_0000;
   localparam int MEMW = 640;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_done = 1'b0;
   logic        mem_hold, mem_rd_en;
   logic [9:0]  mem_rd_addr;
   logic [31:0] mem_rd_data = '0;
   logic        wb_valid;
   logic        wb_ready = 1'b0;
   logic [31:0] wb_addr, wb_data;
   logic        wb_last, pass_done;

   always #10 clk = ~clk;

   ctr_mirror_scan #(.GLB_BASE(GLB), .STAT_BASE(STAT)) u_dut (
      .clk (clk), .rst_n (rst_n), .op_done (op_done),
      .mem_hold (mem_hold), .mem_rd_en (mem_rd_en), .mem_rd_addr (mem_rd_addr),
      .mem_rd_data (mem_rd_data), .wb_valid (wb_valid), .wb_ready (wb_ready),
      .wb_addr (wb_addr), .wb_data (wb_data), .wb_last (wb_last), .pass_done (pass_done)
   );

   logic [31:0] mem [MEMW];

   always @(posedge clk) begin
      if (mem_rd_en && mem_rd_addr < 10'(MEMW)) mem_rd_data <= mem[mem_rd_addr];
   end

   int checks = 0, fails = 0, cyc = 0;
   int bk = 0, bursts_done = 0, beat_i = 0, ops_win = 0, hold_len = 0;
   bit last_op = 0, hold_prev = 0, pass_pend = 0, hold_s = 0;
   bit pv_valid = 0, pv_rdy = 0, pv_last = 0;
   logic [31:0] pv_addr = '0, pv_data = '0;
   logic [31:0] snap [8];

   function automatic int exp_word(input int k);
      return (k < 8) ? k * 8 : 128 + (k - 8) * 8;
   endfunction

   function automatic logic [31:0] exp_ext(input int k);
      return (k < 8) ? GLB + 32'(k * 32) : STAT + 32'((k - 8) * 32);
   endfunction

   task automatic fail_msg(input string req, input logic [31:0] act, input logic [31:0] exp);
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
   endtask

   task automatic step(input bit want_op, input bit rdy);
      bit op;
      int w;
      @(negedge clk);
      cyc++;
      hold_s = mem_hold;
      // R7: pulse exactly after the final beat of a pass
      if (pass_pend) begin
         checks++;
         if (pass_done !== 1'b1) fail_msg("R7 pass_done", 32'(pass_done), 32'd1);
      end else if (pass_done !== 1'b0) begin
         checks++;
         fail_msg("R7 stray pass_done", 32'(pass_done), 32'd0);
      end
      pass_pend = 0;
      // R1 and R2 at the start of a hold window
      if (hold_s && !hold_prev) begin
         checks++;
         if (ops_win - int'(last_op) < 7) fail_msg("R1 ops before grant", 32'(ops_win - int'(last_op)), 32'd7);
         ops_win = int'(last_op);
         for (int i = 0; i < 8; i++) snap[i] = mem[exp_word(bk) + i];
         beat_i = 0;
      end
      if (hold_s) begin
         hold_len++;
         checks++;
         if (mem_rd_addr !== 10'(exp_word(bk) + hold_len - 1))
            fail_msg("R2 read address", 32'(mem_rd_addr), 32'(exp_word(bk) + hold_len - 1));
      end else if (hold_prev) begin
         checks++;
         if (hold_len != 8) fail_msg("R2 hold length", 32'(hold_len), 32'd8);
         hold_len = 0;
      end
      // R6 stall stability
      if (pv_valid && !pv_rdy) begin
         checks++;
         if (wb_valid !== 1'b1 || wb_addr !== pv_addr || wb_data !== pv_data || wb_last !== pv_last)
            fail_msg("R6 stalled beat changed", wb_data, pv_data);
      end
      // beat accepted at the coming edge
      if (wb_valid && rdy) begin
         checks++;
         if (wb_addr !== exp_ext(bk)) fail_msg("R4 R5 burst address", wb_addr, exp_ext(bk));
         checks++;
         if (wb_data !== snap[beat_i]) fail_msg("R3 beat data", wb_data, snap[beat_i]);
         checks++;
         if (wb_last !== (beat_i == 7)) fail_msg("R3 last flag", 32'(wb_last), 32'(beat_i == 7));
         beat_i++;
         if (beat_i == 8 || wb_last) begin
            if (bk == 71) pass_pend = 1;
            bk = (bk + 1) % 72;
            bursts_done++;
            beat_i = 0;
         end
      end
      pv_valid = wb_valid; pv_rdy = rdy; pv_addr = wb_addr; pv_data = wb_data; pv_last = wb_last;
      hold_prev = hold_s;
      // drive: update engine model is stalled by hold
      op = want_op && !hold_s;
      if (op) begin
         w = int'($urandom % MEMW);
         mem[w] = mem[w] + 32'h0000_0101;
         ops_win++;
      end
      last_op = op;
      op_done = op;
      wb_ready = rdy;
   endtask

   initial begin
      int stall;
      bit h1;
      void'($urandom(32'd20240611));
      for (int i = 0; i < MEMW; i++) mem[i] = 32'hC0DE_0000 ^ (32'(i) * 32'h0001_0003);
      // R8: quiet outputs while in reset and just after
      repeat (3) begin
         @(negedge clk);
         checks++;
         if ({mem_hold, mem_rd_en, wb_valid, pass_done} !== 4'b0)
            fail_msg("R8 reset outputs", 32'({mem_hold, mem_rd_en, wb_valid, pass_done}), 32'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if ({mem_hold, mem_rd_en, wb_valid, pass_done} !== 4'b0)
         fail_msg("R8 after reset", 32'({mem_hold, mem_rd_en, wb_valid, pass_done}), 32'd0);
      // R1 directed: six operations are not enough
      repeat (6) step(1'b1, 1'b1);
      h1 = 0;
      repeat (5) begin
         step(1'b0, 1'b1);
         h1 |= hold_s;
      end
      checks++;
      if (h1) fail_msg("R1 grant after six ops", 32'd1, 32'd0);
      // seventh operation: hold must rise exactly one edge after it is registered
      step(1'b1, 1'b1);
      step(1'b0, 1'b1);
      checks++;
      if (hold_s) fail_msg("R1 early hold", 32'd1, 32'd0);
      step(1'b0, 1'b1);
      checks++;
      if (!hold_s) fail_msg("R1 hold after seventh op", 32'd0, 32'd1);
      // directed long stall on the first burst for R6
      repeat (9) step(1'b0, 1'b1);
      repeat (12) step(1'b1, 1'b0);
      // random traffic over two full passes and a wrap (R3 R4 R5 R7)
      stall = 0;
      while (bursts_done < 150 && cyc < 150000) begin
         bit rdy;
         if (stall > 0) begin
            stall--;
            rdy = 1'b0;
         end else begin
            if ($urandom % 50 == 0) stall = 10;
            rdy = ($urandom % 4) != 0;
         end
         step(($urandom % 2) == 1, rdy);
      end
      if (cyc >= 150000) begin
         checks++;
         fail_msg("watchdog", 32'(bursts_done), 32'd150);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule